// File: doc/BRIEF.md
# Atomic Set/Clear GPIO Register Port

This block is a 32-bit memory-mapped general-purpose I/O port. Each pin has an output latch and an output-enable. Software never rewrites either of them directly. It writes a mask to a set register or to a clear register, and only the bits that are 1 in the mask change. Two software contexts that each own different pins can therefore update their pins without a read-modify-write and without a lock.

Pin inputs pass through a two-flop synchronizer before they are presented to software. The pad drivers sit outside the block: the block supplies a level and an enable for each pin and takes back the level seen at the pad.

The bus port is a single-cycle valid/write interface with byte offsets. Writes take effect at the clock edge where they are presented. Read data is registered and appears on the cycle after the read. Bit i of every data word belongs to pin i, and byte 0 of the word carries pins 7..0 (little-endian).

Top module: `gpio_setclr_port`

## Requirements
- R1: After a clock edge with `rst_n` low, every output latch bit, every output-enable bit and `bus_rdata` are 0, so all pins are tri-stated.
- R2: A write (`bus_valid`=1, `bus_write`=1) to offset 0x00 sets each latch bit whose data bit is 1 and leaves the other latch bits unchanged. The new value is on `pin_out` after that edge.
- R3: A write to offset 0x10 clears each latch bit whose data bit is 1 and leaves the other latch bits unchanged.
- R4: A write to offset 0x20 sets the output-enable of each pin whose data bit is 1 and leaves the others unchanged. The result is on `pin_oe` after that edge.
- R5: A write to offset 0x30 clears the output-enable of each pin whose data bit is 1, which tri-states that pin. The others are unchanged.
- R6: A read (`bus_valid`=1, `bus_write`=0) loads `bus_rdata` at that edge. Offsets 0x00 and 0x10 return the latch word, and offsets 0x20 and 0x30 return the output-enable word.
- R7: A read of offset 0x40 returns the pin levels after two synchronizer flops. The value read at edge n is `pin_in` as sampled at edge n-2, with bit i = pin i.
- R8: Reads of any offset other than 0x00, 0x10, 0x20, 0x30 and 0x40 return 0. Writes to those offsets change neither latch nor enable.
- R9: `bus_rdata` holds its value on every cycle that has no read, including cycles with writes.
- R10: While `bus_valid` is 0, `bus_write`, `bus_addr` and `bus_wdata` have no effect on latch, enable or read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Transfer request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write mask (bit i = pin i) |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous levels from the pads |
| pin_out | output | 32 | Output latch, one bit per pin |
| pin_oe | output | 32 | Output-enable, one bit per pin (1 = drive) |

## Verification
A wrong latch or enable bit shows at once on `pin_out` or `pin_oe` after the edge that should have set it. Because those outputs are compared on every cycle, a corrupted untouched bit or a mask applied to the wrong register is caught within one cycle. A synchronizer with the wrong depth or a wrong mux select shows only through read data, one cycle after a read. For that reason the stimulus reads every offset often and changes the pins just before reads of 0x40, so that a latency off by one cycle returns a stale or early word. A decoder that aliases an unmapped offset shows as a nonzero read, or as a latch or enable change after a write that should have been ignored.

// File: rtl/gpio_setclr_pkg.sv
// Package: shared offsets and decoded-select type for the set/clear GPIO port.
// Assumes byte offsets on a 32-bit register bus; offsets are fixed by software.
package gpio_setclr_pkg;

    localparam int OFS_OUT_SET = 'h00;
    localparam int OFS_OUT_CLR = 'h10;
    localparam int OFS_OE_SET  = 'h20;
    localparam int OFS_OE_CLR  = 'h30;
    localparam int OFS_PIN_RD  = 'h40;

    // One field per mapped register; at most one is set for any address.
    typedef struct packed {
        logic out_set;
        logic out_clr;
        logic oe_set;
        logic oe_clr;
        logic pin_rd;
    } gpio_sel_t;

endpackage

// File: rtl/gpio_addr_decode.sv
// Module: decodes a byte offset into a one-hot register select.
// Assumes exact offset match; any other offset yields an all-zero select.
module gpio_addr_decode
    import gpio_setclr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output gpio_sel_t         sel
);

    // Compare the offset against each mapped register.
    always_comb begin
        sel         = '0;
        sel.out_set = (addr == ADDR_W'(OFS_OUT_SET));
        sel.out_clr = (addr == ADDR_W'(OFS_OUT_CLR));
        sel.oe_set  = (addr == ADDR_W'(OFS_OE_SET));
        sel.oe_clr  = (addr == ADDR_W'(OFS_OE_CLR));
        sel.pin_rd  = (addr == ADDR_W'(OFS_PIN_RD));
    end

endmodule

// File: rtl/gpio_setclr_bank.sv
// Module: a bank of state bits changed only by write-one-to-set and
// write-one-to-clear masks. Assumes set_en and clr_en are never both high
// (the bus addresses one register per cycle); set wins if they are.
module gpio_setclr_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] q
);

    // One cell per pin so that each bit changes independently of its neighbours.
    for (genvar g = 0; g < WIDTH; g++) begin : g_cell
        // Update this bit from the masked set/clear strobes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[g] <= 1'b0;
            else if (set_en && mask[g])
                q[g] <= 1'b1;
            else if (clr_en && mask[g])
                q[g] <= 1'b0;
        end
    end

    // R2, R4
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((q & $past(mask)) == $past(mask)));

    // R3, R5
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((q & $past(mask)) == '0));

    // R2, R3, R4, R5
    untouched_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en || clr_en) |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask))));

    // R8, R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(q));

endmodule

// File: rtl/gpio_in_sync.sv
// Module: a multi-flop synchronizer for the pin inputs, one chain per pin.
// Assumes each pin is independent; no cross-bit coherence is promised.
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the raw pad level.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= pin_in;
            end
        end else begin : g_next
            // Pass the level one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign pin_sync = stage_q[STAGES-1];

    if (STAGES == 2) begin : g_chk2
        // R7
        sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_n, 2)) |-> (pin_sync == $past(pin_in, 2)));
    end

endmodule

// File: rtl/gpio_read_mux.sv
// Module: selects the word returned by a read from the decoded select.
// Assumes sel is one-hot or zero; zero select returns zero.
module gpio_read_mux
    import gpio_setclr_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int DATA_W = 32
) (
    input  gpio_sel_t         sel,
    input  logic [WIDTH-1:0]  latch_q,
    input  logic [WIDTH-1:0]  oe_q,
    input  logic [WIDTH-1:0]  pin_sync,
    output logic [DATA_W-1:0] rd_word
);

    // Both the set and the clear offsets of a bank read back that bank.
    always_comb begin
        rd_word = '0;
        if (sel.out_set || sel.out_clr) rd_word = DATA_W'(latch_q);
        if (sel.oe_set  || sel.oe_clr)  rd_word = DATA_W'(oe_q);
        if (sel.pin_rd)                 rd_word = DATA_W'(pin_sync);
    end

endmodule

// File: rtl/gpio_setclr_port.sv
// Module: top of the set/clear GPIO port. It decodes the bus, updates the
// latch and enable banks, synchronizes the pins and registers read data.
// Assumes NUM_PINS <= DATA_W and a single-cycle valid/write bus.
module gpio_setclr_port
    import gpio_setclr_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    localparam int MASK_W = NUM_PINS;

    gpio_sel_t           sel;
    logic                wr_req;
    logic                rd_req;
    logic [MASK_W-1:0]   wmask;
    logic [NUM_PINS-1:0] pin_sync;
    logic [DATA_W-1:0]   rd_word;

    assign wr_req = bus_valid && bus_write;
    assign rd_req = bus_valid && !bus_write;
    assign wmask  = bus_wdata[MASK_W-1:0];

    gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_setclr_bank #(.WIDTH(NUM_PINS)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_req && sel.out_set),
        .clr_en (wr_req && sel.out_clr),
        .mask   (wmask),
        .q      (pin_out)
    );

    gpio_setclr_bank #(.WIDTH(NUM_PINS)) u_oe (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_req && sel.oe_set),
        .clr_en (wr_req && sel.oe_clr),
        .mask   (wmask),
        .q      (pin_oe)
    );

    gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    gpio_read_mux #(.WIDTH(NUM_PINS), .DATA_W(DATA_W)) u_rmux (
        .sel      (sel),
        .latch_q  (pin_out),
        .oe_q     (pin_oe),
        .pin_sync (pin_sync),
        .rd_word  (rd_word)
    );

    // Register read data on a read; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_req)
            bus_rdata <= rd_word;
    end

    // R8
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (sel == '0)) |=> (bus_rdata == '0));

    // R9, R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(bus_rdata));

    // R6
    latch_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (sel.out_set || sel.out_clr)) |=> (bus_rdata == DATA_W'($past(pin_out))));

    // R6
    oe_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (sel.oe_set || sel.oe_clr)) |=> (bus_rdata == DATA_W'($past(pin_oe))));

endmodule

// File: tb/sim_gpio_setclr_port.sv
// Bench: behavioural reference model (queue for the synchronizer history),
// compared against every output on every clock, plus directed corner cases.
module sim_gpio_setclr_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] m_latch = '0;
    logic [31:0] m_oe    = '0;
    logic [31:0] m_rdata = '0;
    logic [31:0] m_hist[$];

    always #2.5 clk = ~clk;

    gpio_setclr_port u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Model one clock edge from the inputs held during the cycle.
    task automatic model_edge();
        logic [31:0] synced;
        synced = m_hist[0];
        if (!rst_n) begin
            m_latch = '0;
            m_oe    = '0;
            m_rdata = '0;
            m_hist  = '{32'h0, 32'h0};
        end else begin
            if (bus_valid && bus_write) begin
                case (bus_addr)
                    8'h00: m_latch = m_latch | bus_wdata;
                    8'h10: m_latch = m_latch & ~bus_wdata;
                    8'h20: m_oe    = m_oe | bus_wdata;
                    8'h30: m_oe    = m_oe & ~bus_wdata;
                    default: ;
                endcase
            end else if (bus_valid) begin
                case (bus_addr)
                    8'h00, 8'h10: m_rdata = m_latch;
                    8'h20, 8'h30: m_rdata = m_oe;
                    8'h40:        m_rdata = synced;
                    default:      m_rdata = '0;
                endcase
            end
            m_hist.push_back(pin_in);
            void'(m_hist.pop_front());
        end
    endtask

    // Drive one cycle from a negedge, advance, compare at the next negedge.
    task automatic step(input logic v, input logic w, input logic [7:0] a,
                        input logic [31:0] d, input string tag);
        bus_valid = v;
        bus_write = w;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, "pin_out", pin_out, m_latch);
        check(tag, "pin_oe", pin_oe, m_oe);
        check(tag, "bus_rdata", bus_rdata, m_rdata);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(1'b1, 1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(1'b1, 1'b0, a, 32'h0, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] offs[8] = '{8'h00, 8'h10, 8'h20, 8'h30, 8'h40, 8'h04, 8'h50, 8'hFC};
        m_hist = '{32'h0, 32'h0};
        @(negedge clk);
        // R1: reset state, with pins and bus busy during reset
        rst_n  = 1'b0;
        pin_in = 32'hFFFF_FFFF;
        step(1'b1, 1'b1, 8'h00, 32'hFFFF_FFFF, "R1");
        step(1'b1, 1'b1, 8'h20, 32'hFFFF_FFFF, "R1");
        check("R1", "pin_out reset", pin_out, 32'h0);
        check("R1", "pin_oe reset", pin_oe, 32'h0);
        check("R1", "bus_rdata reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        rd(8'h40, "R1");
        check("R1", "sync reset read", bus_rdata, 32'h0);

        // R2: set masks accumulate, other bits untouched
        wr(8'h00, 32'hA5A5_0F0F, "R2");
        wr(8'h00, 32'h0000_F000, "R2");
        check("R2", "pin_out after sets", pin_out, 32'hA5A5_FF0F);
        wr(8'h00, 32'h0, "R2");
        // R3: clear mask
        wr(8'h10, 32'h8001_0F00, "R3");
        check("R3", "pin_out after clear", pin_out, 32'h25A4_F00F);
        wr(8'h10, 32'h0, "R3");
        // R4 and R5: enable then tri-state
        wr(8'h20, 32'hFFFF_0000, "R4");
        wr(8'h20, 32'h0000_0001, "R4");
        check("R4", "pin_oe after enable", pin_oe, 32'hFFFF_0001);
        wr(8'h30, 32'h0F0F_0001, "R5");
        check("R5", "pin_oe after tristate", pin_oe, 32'hF0F0_0000);
        // R6: read back from every bank offset
        rd(8'h00, "R6");
        check("R6", "read 0x00", bus_rdata, 32'h25A4_F00F);
        rd(8'h30, "R6");
        check("R6", "read 0x30", bus_rdata, 32'hF0F0_0000);
        rd(8'h10, "R6");
        rd(8'h20, "R6");
        // R9: writes leave read data alone
        wr(8'h00, 32'h0000_0010, "R9");
        check("R9", "rdata held over write", bus_rdata, 32'hF0F0_0000);
        step(1'b0, 1'b0, 8'h00, 32'h0, "R9");
        // R7: pin change right before reads shows the two-flop delay
        pin_in = 32'h1234_5678;
        rd(8'h40, "R7");
        check("R7", "read 0x40 +1", bus_rdata, 32'hFFFF_FFFF);
        rd(8'h40, "R7");
        check("R7", "read 0x40 +2", bus_rdata, 32'hFFFF_FFFF);
        rd(8'h40, "R7");
        check("R7", "read 0x40 +3", bus_rdata, 32'h1234_5678);
        pin_in = 32'h8000_0001;
        rd(8'h40, "R7");
        rd(8'h40, "R7");
        rd(8'h40, "R7");
        check("R7", "bit order", bus_rdata, 32'h8000_0001);
        // R8: unmapped offsets
        wr(8'h04, 32'hFFFF_FFFF, "R8");
        wr(8'h50, 32'hFFFF_FFFF, "R8");
        wr(8'h40, 32'hFFFF_FFFF, "R8");
        wr(8'h14, 32'hFFFF_FFFF, "R8");
        rd(8'h08, "R8");
        check("R8", "unmapped read", bus_rdata, 32'h0);
        rd(8'hFC, "R8");
        // R10: bus_valid low ignores everything else
        step(1'b0, 1'b1, 8'h00, 32'hFFFF_FFFF, "R10");
        step(1'b0, 1'b1, 8'h30, 32'hFFFF_FFFF, "R10");
        step(1'b0, 1'b0, 8'h40, 32'h0, "R10");
        check("R10", "pin_oe after idle writes", pin_oe, 32'hF0F0_0000);
        // Mixed traffic compared on every clock
        for (int i = 0; i < 3000; i++) begin
            pin_in = ($urandom_range(0, 3) == 0) ? $urandom() : pin_in;
            step(($urandom_range(0, 7) != 0), $urandom_range(0, 1) == 1,
                 offs[$urandom_range(0, 7)], $urandom(), "R2 R3 R4 R5 R6 R7 R8 R9 R10");
        end
        // R1: mid-run reset
        rst_n = 1'b0;
        step(1'b1, 1'b0, 8'h00, 32'h0, "R1");
        check("R1", "pin_oe second reset", pin_oe, 32'h0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 8'h00, 32'h0, "R1");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule